// File: doc/BRIEF.md
# Nested Logic Pattern Trigger

This block watches four logic channels that are already synchronised to the sample clock. It raises a trigger pulse when a programmed Boolean pattern over all four channels becomes true. Two patterns, A and B, are held in configuration. The trigger can follow A alone or B alone. In the chained mode, an occurrence of A arms the block and a later occurrence of B fires it.

A pattern must stay true for a programmable number of sample cycles before it counts. An external clock can restrict pattern evaluation to that clock's rising edges. While the inhibit input is high, no trigger is produced and any armed state is dropped.

The trigger output carries either the one-cycle trigger pulse or a gate that spans the time between arming and firing. A monitor output shows either the active pattern's accepted level or the synchronised external clock. Configuration is written through a four-word register port.

Top module: `pattern_trigger`

## Requirements
- R1: After reset, trig_o and mon_o are 0. Both patterns reset to the never-true value (invert bit set, every channel don't-care). The filter length resets to 0, the mode to A-only, and all option bits to 0. No trigger occurs until a pattern is written.
- R2: The channel c term of a pattern uses bits [2c+1:2c]. Bit 2c+1 set means "care", and bit 2c gives the required level. With the care bit clear (codes 00 and 01) the channel is don't-care. Bit 8 inverts the AND of the four terms.
- R3: Register writes take effect on the clock edge where cfg_we_i is high. Address 0 holds pattern A and address 1 holds pattern B. Address 2 is the control word: bits [1:0] select the mode (0 = A only, 1 = B only, 2 and 3 = A then B), bit 2 enables clock qualification, bit 3 selects the gate output, and bit 4 selects the external clock for the monitor. Address 3 holds the filter length.
- R4: In A-only mode, trig_o goes high for one cycle, one clock after the edge at which pattern A first becomes accepted. In B-only mode the same holds for pattern B.
- R5: In A-then-B mode, a new acceptance of A arms the block, and a later new acceptance of B fires the trigger and returns the block to idle. A B acceptance that comes before arming, or in the arming cycle itself, fires nothing. After firing, B alone does not fire again until A occurs anew.
- R6: With filter length F, a pattern is accepted at the (F+1)th consecutive sample edge at which it is true. A pattern true for fewer edges is never accepted. F = 0 accepts a pattern at once.
- R7: With qualification enabled, a pattern counts only in the single cycle that marks a rising edge of ext_clk_i. That edge is seen after a two-flop synchroniser, so trig_o rises three clocks after ext_clk_i rises. No edge means no trigger.
- R8: While inhibit_i is high, no trigger is issued and the armed state is cleared, so the gate output drops to 0 one clock later.
- R9: With the gate output selected, trig_o is high from the clock after A arms the block until the clock on which B fires it.
- R10: When bit 4 is clear, mon_o is the registered accepted level of pattern A (in A-only mode) or of pattern B (in the other modes). When bit 4 is set, mon_o is the synchronised ext_clk_i delayed by one register, so it rises three clocks after the input.
- R11: A pattern that stays accepted produces exactly one trigger pulse. trig_o is never high in two consecutive cycles in pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| chan_i | input | NUM_CH | Synchronised logic channels |
| ext_clk_i | input | 1 | External qualifying clock, asynchronous |
| inhibit_i | input | 1 | Blocks triggering and clears arming while high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| trig_o | output | 1 | Trigger pulse or A-to-B gate |
| mon_o | output | 1 | Accepted pattern level or synchronised external clock |

## Verification
Faults in the internal state show up at the ports within one or two clocks:
- A stuck armed flag shows on the gate output in the cycle after the inhibit pulse, or as a trigger from B alone.
- A lost previous-event flag shows as a second pulse while a pattern is held.
- A filter counter that is off by one moves the first trigger one clock earlier or later.
- A wrong synchroniser depth shifts the qualified trigger and the monitored clock by one clock.

The bench steps through these windows cycle by cycle, and compares each port against expected values that it derives from the requirements.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;

    typedef enum logic [1:0] {
        M_ONLY_A   = 2'd0,
        M_ONLY_B   = 2'd1,
        M_A_THEN_B = 2'd2,
        M_CHAIN_2  = 2'd3
    } trig_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

    localparam int REG_PAT_A = 0;
    localparam int REG_PAT_B = 1;
    localparam int REG_CTRL  = 2;
    localparam int REG_FILT  = 3;

endpackage

// File: rtl/ptrig_cond.sv
module ptrig_cond #(
    parameter int NUM_CH = 4,
    parameter int FILT_W = 5,
    localparam int PAT_W = 2 * NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_i,
    input  logic [PAT_W-1:0]  pat_i,
    input  logic [FILT_W-1:0] filt_i,
    output logic              ok_o
);

    typedef struct packed {
        logic [FILT_W-1:0] cnt;
    } cond_state_t;

    cond_state_t s_d, s_q;
    logic [NUM_CH-1:0] term;
    logic              cond;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_term
        assign term[c] = ~pat_i[2*c+1] | (chan_i[c] == pat_i[2*c]);
    end

    assign cond = (&term) ^ pat_i[PAT_W-1];

    always_comb begin
        s_d = s_q;
        if (!cond) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != {FILT_W{1'b1}}) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ok_o = cond && (s_q.cnt >= filt_i);

    // R6: with a nonzero filter, acceptance needs the pattern true one edge earlier
    p_filter_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && filt_i != '0) |-> $past(cond));

endmodule

// File: rtl/ptrig_qual.sv
module ptrig_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
    } qual_state_t;

    qual_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[SYNC_STAGES-1:0], ext_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.sh[SYNC_STAGES-1];
    assign rise_o  = s_q.sh[SYNC_STAGES-1] & ~s_q.sh[SYNC_STAGES];

    // R7: a qualifying edge marks exactly one cycle
    p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger
    import ptrig_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int FILT_W      = 5,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_i,
    input  logic              ext_clk_i,
    input  logic              inhibit_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic              trig_o,
    output logic              mon_o
);

    localparam int PAT_W = 2 * NUM_CH + 1;
    localparam logic [PAT_W-1:0] PAT_NEVER = {1'b1, {(PAT_W-1){1'b0}}};

    typedef struct packed {
        logic [PAT_W-1:0]  pat_a;
        logic [PAT_W-1:0]  pat_b;
        trig_mode_e        mode;
        logic              qual_en;
        logic              gate_out;
        logic              mon_ext;
        logic [FILT_W-1:0] filt;
    } cfg_t;

    typedef struct packed {
        cfg_t       cfg;
        arm_state_e state;
        logic       ev_a_prev;
        logic       ev_b_prev;
        logic       trig;
        logic       mon;
    } top_state_t;

    top_state_t r_d, r_q;
    logic ok_a, ok_b;
    logic q_level, q_rise;
    logic ev_a, ev_b, rise_a, rise_b, fire;

    ptrig_cond #(.NUM_CH(NUM_CH), .FILT_W(FILT_W)) u_cond_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .chan_i (chan_i),
        .pat_i  (r_q.cfg.pat_a),
        .filt_i (r_q.cfg.filt),
        .ok_o   (ok_a)
    );

    ptrig_cond #(.NUM_CH(NUM_CH), .FILT_W(FILT_W)) u_cond_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .chan_i (chan_i),
        .pat_i  (r_q.cfg.pat_b),
        .filt_i (r_q.cfg.filt),
        .ok_o   (ok_b)
    );

    ptrig_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_i   (ext_clk_i),
        .level_o (q_level),
        .rise_o  (q_rise)
    );

    always_comb begin
        r_d = r_q;

        if (cfg_we_i) begin
            case (cfg_addr_i)
                2'(REG_PAT_A): r_d.cfg.pat_a = cfg_wdata_i[PAT_W-1:0];
                2'(REG_PAT_B): r_d.cfg.pat_b = cfg_wdata_i[PAT_W-1:0];
                2'(REG_CTRL): begin
                    r_d.cfg.mode     = trig_mode_e'(cfg_wdata_i[1:0]);
                    r_d.cfg.qual_en  = cfg_wdata_i[2];
                    r_d.cfg.gate_out = cfg_wdata_i[3];
                    r_d.cfg.mon_ext  = cfg_wdata_i[4];
                end
                default: r_d.cfg.filt = cfg_wdata_i[FILT_W-1:0];
            endcase
        end

        ev_a   = ok_a & (~r_q.cfg.qual_en | q_rise);
        ev_b   = ok_b & (~r_q.cfg.qual_en | q_rise);
        rise_a = ev_a & ~r_q.ev_a_prev;
        rise_b = ev_b & ~r_q.ev_b_prev;
        r_d.ev_a_prev = ev_a;
        r_d.ev_b_prev = ev_b;

        fire = 1'b0;
        case (r_q.cfg.mode)
            M_ONLY_A: begin
                fire      = rise_a;
                r_d.state = ST_IDLE;
            end
            M_ONLY_B: begin
                fire      = rise_b;
                r_d.state = ST_IDLE;
            end
            default: begin
                if (r_q.state == ST_ARMED) begin
                    if (rise_b) begin
                        fire      = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end else if (rise_a) begin
                    r_d.state = ST_ARMED;
                end
            end
        endcase

        if (inhibit_i) begin
            fire      = 1'b0;
            r_d.state = ST_IDLE;
        end

        r_d.trig = fire;
        if (r_q.cfg.mon_ext) begin
            r_d.mon = q_level;
        end else if (r_q.cfg.mode == M_ONLY_A) begin
            r_d.mon = ev_a;
        end else begin
            r_d.mon = ev_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.cfg.pat_a <= PAT_NEVER;
            r_q.cfg.pat_b <= PAT_NEVER;
            r_q.cfg.mode  <= M_ONLY_A;
            r_q.state     <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign trig_o = r_q.cfg.gate_out ? (r_q.state == ST_ARMED) : r_q.trig;
    assign mon_o  = r_q.mon;

    // R11: a trigger pulse never lasts two cycles
    p_trig_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.trig |=> !r_q.trig);

    // R8: inhibit leaves no trigger and no armed state behind
    p_inhibit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> (!r_q.trig && r_q.state == ST_IDLE));

    // R5: in chained mode a trigger needs the armed state one cycle before
    p_chain_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.trig && $past(r_q.cfg.mode[1])) |-> $past(r_q.state == ST_ARMED));

    // R7: with qualification on, a trigger follows a qualifying edge
    p_qual_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.trig && $past(r_q.cfg.qual_en)) |-> $past(q_rise));

endmodule

// File: tb/pattern_trigger_bench.sv
module pattern_trigger_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan = 4'b0;
    logic       ext_clk = 1'b0;
    logic       inhibit = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'b0;
    logic [15:0] cfg_wdata = 16'b0;
    logic       trig;
    logic       mon;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pattern_trigger u_pattern_trigger (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_i      (chan),
        .ext_clk_i   (ext_clk),
        .inhibit_i   (inhibit),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .trig_o      (trig),
        .mon_o       (mon)
    );

    // {pattern[8:0], channels[3:0], expected}
    localparam logic [13:0] VEC [0:11] = '{
        {9'h0FF, 4'b1111, 1'b1},
        {9'h0FF, 4'b1110, 1'b0},
        {9'h0AA, 4'b0000, 1'b1},
        {9'h0AA, 4'b0100, 1'b0},
        {9'h000, 4'b1010, 1'b1},
        {9'h1FF, 4'b1111, 1'b0},
        {9'h1FF, 4'b0111, 1'b1},
        {9'h023, 4'b0001, 1'b1},
        {9'h023, 4'b0101, 1'b0},
        {9'h023, 4'b1011, 1'b1},
        {9'h043, 4'b0001, 1'b1},
        {9'h043, 4'b1000, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset trig", trig, 1'b0);
        chk("R1 reset mon", mon, 1'b0);
        chan = 4'b1111;
        for (int j = 0; j < 3; j++) begin
            tick();
            chk("R1 never-true pattern", trig, 1'b0);
        end

        // R2/R3/R4: pattern coding walked in A-only mode, filter 0
        for (int i = 0; i < 12; i++) begin
            chan = VEC[i][4:1];
            wr(2'd0, 16'h0100);
            tick();
            wr(2'd0, {7'b0, VEC[i][13:5]});
            tick();
            chk($sformatf("R2 R4 vector %0d", i), trig, VEC[i][0]);
            if (VEC[i][0]) begin
                tick();
                chk($sformatf("R11 vector %0d single pulse", i), trig, 1'b0);
            end
        end

        // R6: filter length 3
        chan = 4'b0000;
        wr(2'd0, 16'h00FF);
        wr(2'd3, 16'd3);
        tick();
        chan = 4'b1111;
        for (int j = 0; j < 3; j++) begin
            tick();
            chk("R6 short pattern", trig, 1'b0);
        end
        chan = 4'b0000;
        tick(); chk("R6 short rejected", trig, 1'b0);
        tick(); chk("R6 short rejected late", trig, 1'b0);
        chan = 4'b1111;
        for (int j = 0; j < 3; j++) begin
            tick();
            chk("R6 before F+1 edges", trig, 1'b0);
        end
        tick(); chk("R6 accepted at F+1", trig, 1'b1);
        tick(); chk("R11 held pattern", trig, 1'b0);
        chan = 4'b0000;
        wr(2'd3, 16'd0);

        // R4: B-only mode
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'h000C);
        wr(2'd2, 16'h0001);
        chan = 4'b0001;
        tick(); chk("R4 A ignored in B mode", trig, 1'b0);
        tick(); chk("R4 A ignored in B mode", trig, 1'b0);
        chan = 4'b0010;
        tick(); chk("R4 B fires", trig, 1'b1);
        tick(); chk("R11 B single", trig, 1'b0);
        chan = 4'b0000;

        // R5: A then B
        wr(2'd2, 16'h0002);
        tick();
        chan = 4'b0010;
        tick(); chk("R5 B before arm", trig, 1'b0);
        tick(); chk("R5 B before arm", trig, 1'b0);
        chan = 4'b0000;
        tick();
        chan = 4'b0011;
        tick(); chk("R5 B same cycle as arm", trig, 1'b0);
        tick(); chk("R5 B held no new", trig, 1'b0);
        chan = 4'b0001;
        tick(); chk("R5 B dropped", trig, 1'b0);
        chan = 4'b0011;
        tick(); chk("R5 later B fires", trig, 1'b1);
        tick(); chk("R11 chained single", trig, 1'b0);
        chan = 4'b0010;
        tick(); chk("R5 idle after fire", trig, 1'b0);
        chan = 4'b0000;
        tick(); chk("R5 idle after fire", trig, 1'b0);
        chan = 4'b0010;
        tick(); chk("R5 B without new A", trig, 1'b0);
        chan = 4'b0000;

        // R9: gate output
        wr(2'd2, 16'h000A);
        tick(); chk("R9 gate idle", trig, 1'b0);
        chan = 4'b0001;
        tick(); chk("R9 gate after arm", trig, 1'b1);
        tick(); chk("R9 gate held", trig, 1'b1);
        chan = 4'b0011;
        tick(); chk("R9 gate ends at fire", trig, 1'b0);

        // R8: inhibit clears arming
        chan = 4'b0000;
        tick();
        chan = 4'b0001;
        tick(); chk("R8 gate armed", trig, 1'b1);
        inhibit = 1'b1;
        tick(); chk("R8 inhibit drops gate", trig, 1'b0);
        inhibit = 1'b0;
        tick(); chk("R8 stays idle", trig, 1'b0);
        wr(2'd2, 16'h0002);
        chan = 4'b0000;
        tick();
        chan = 4'b0001;
        tick();
        inhibit = 1'b1;
        tick(); chk("R8 no trig inhibited", trig, 1'b0);
        inhibit = 1'b0;
        chan = 4'b0011;
        tick(); chk("R8 arm cleared", trig, 1'b0);
        tick(); chk("R8 arm cleared", trig, 1'b0);
        chan = 4'b0000;
        wr(2'd2, 16'h0000);
        tick();
        inhibit = 1'b1;
        chan = 4'b0001;
        tick(); chk("R8 A-only inhibited", trig, 1'b0);
        tick(); chk("R8 A-only inhibited", trig, 1'b0);
        inhibit = 1'b0;
        chan = 4'b0000;

        // R7: clock qualification
        wr(2'd2, 16'h0004);
        chan = 4'b0001;
        for (int j = 0; j < 3; j++) begin
            tick();
            chk("R7 no edge no trig", trig, 1'b0);
        end
        ext_clk = 1'b1;
        tick(); chk("R7 sync stage 1", trig, 1'b0);
        tick(); chk("R7 sync stage 2", trig, 1'b0);
        tick(); chk("R7 qualified fire", trig, 1'b1);
        tick(); chk("R7 single", trig, 1'b0);
        ext_clk = 1'b0;
        tick(); tick();
        chan = 4'b0000;
        ext_clk = 1'b1;
        for (int j = 0; j < 4; j++) begin
            tick();
            chk("R7 edge without pattern", trig, 1'b0);
        end
        ext_clk = 1'b0;

        // R10: monitor select
        wr(2'd2, 16'h0010);
        tick(); tick(); tick();
        ext_clk = 1'b1;
        tick(); chk("R10 mon ext early", mon, 1'b0);
        tick(); chk("R10 mon ext early", mon, 1'b0);
        tick(); chk("R10 mon ext", mon, 1'b1);
        ext_clk = 1'b0;
        wr(2'd2, 16'h0000);
        tick();
        chan = 4'b0001;
        tick();
        chk("R10 mon level", mon, 1'b1);
        chk("R4 trig with mon", trig, 1'b1);
        tick();
        chk("R10 mon held", mon, 1'b1);
        chk("R11 held single", trig, 1'b0);
        chan = 4'b0000;
        tick(); chk("R10 mon falls", mon, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule